// File: doc/BRIEF.md
# Frequency-then-recency replacement selector

This block holds the replacement state of one set of an N-way associative buffer and names the way to evict when the buffer misses. For every way it keeps a valid flag, a small saturating use counter and a recency rank, where rank 0 is the most recently touched way and rank N-1 the oldest. Every hit or fill presented on the access port updates this state on the next clock edge.

A mode input selects one of two policies. In plain least-recently-used mode the counters are not consulted and the oldest valid way is named. In frequency-first mode the valid way with the smallest use count is named, and among ways with equal counts the one touched longest ago. Empty ways are always named before any valid way. The victim index is combinational from the stored state, the mode and the request input, so a lookup pipeline can read it in the same cycle as its miss.

Top module: `lfru_victim_sel`

## Requirements
- R1: After reset every way is empty and its counter is 0, and way i holds rank i. With all ways empty the victim is way 0 in either mode.
- R2: A fill (access strobe with `acc_fill`=1) marks the addressed way valid and sets its counter to 1, including when the way was already valid with a larger count.
- R3: A hit (access strobe with `acc_fill`=0) raises the addressed way's counter by one, saturating at 15. It never wraps to 0.
- R4: On any access the addressed way takes rank 0, every way whose rank was below the addressed way's old rank moves up by one, and all other ranks keep their values.
- R5: While at least one way is empty, the victim is the lowest-indexed empty way, whatever the mode.
- R6: With `mode_lfru`=0 and all ways valid, the victim is the way of rank N-1; counter values have no effect.
- R7: With `mode_lfru`=1 and all ways valid, the victim is a way with the smallest counter value.
- R8: With `mode_lfru`=1, among valid ways sharing the smallest counter value the victim is the one with the largest rank; a tie that still remains goes to the lowest index.
- R9: `vic_way` depends only on the stored state, the mode and `vic_req`; an access changes it only after the next rising clock edge.
- R10: While `vic_req`=0, `vic_way` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| acc_vld | input | 1 | Access strobe: one hit or fill this cycle |
| acc_way | input | $clog2(WAYS) | Way addressed by the access |
| acc_fill | input | 1 | 1 = fill of the way, 0 = hit on the way |
| mode_lfru | input | 1 | 0 = least recently used, 1 = lowest count then oldest |
| vic_req | input | 1 | Victim request |
| vic_way | output | $clog2(WAYS) | Way to evict, valid while vic_req is high |

## Verification
The assertions take for granted that a hit is only presented for a way that has already been filled, that at most one access arrives per cycle, and that the way index is below WAYS; under these, ranks stay a permutation and counters only move as described. The stimulus respects this by filling every way it later hits, driving one access per clock, and using only indices 0 to 3 with the default four ways. A mid-run reset is exercised so that the empty-first order is checked from a state in which ranks and counts differ from the reset ones.

// File: rtl/lfru_pkg.sv
package lfru_pkg;

  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_LFRU = 1'b1
  } repl_pol_e;

endpackage

// File: rtl/lfru_way_state.sv
module lfru_way_state #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 4,
  parameter int ID    = 0,
  localparam int IDX_W = $clog2(WAYS),
  localparam int RANK_W = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [IDX_W-1:0]  acc_way,
  input  logic              acc_fill,
  input  logic [RANK_W-1:0] acc_rank,
  output logic              valid_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [RANK_W-1:0] rank_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              sel;
  logic              upd_en;
  logic              valid_d;
  logic [CNT_W-1:0]  cnt_d;
  logic [RANK_W-1:0] rank_d;

  assign sel    = acc_vld && (acc_way == IDX_W'(ID));
  assign upd_en = acc_vld;

  always_comb begin
    valid_d = valid_q;
    cnt_d   = cnt_q;
    rank_d  = rank_q;
    if (sel) begin
      rank_d = '0;
      if (acc_fill) begin
        valid_d = 1'b1;
        cnt_d   = CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (rank_q < acc_rank) begin
      rank_d = rank_q + RANK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      rank_q  <= RANK_W'(ID);
    end else if (upd_en) begin
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
      rank_q  <= rank_d;
    end
  end

  // R4: an accessed way is most recent afterwards
  p_mru_after_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (rank_q == '0));

  // R2: a fill leaves the way valid with a count of one
  p_fill_sets_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && acc_fill) |=> (valid_q && cnt_q == CNT_W'(1)));

  // R3: a hit below the ceiling adds exactly one
  p_hit_increments_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !acc_fill && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3: a hit at the ceiling does not wrap
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !acc_fill && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R4: without an access the way keeps its state
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> ($stable(rank_q) && $stable(cnt_q) && $stable(valid_q)));

endmodule

// File: rtl/lfru_victim_pick.sv
module lfru_victim_pick
  import lfru_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(WAYS),
  localparam int RANK_W = IDX_W,
  localparam int KEY_W = 1 + CNT_W + RANK_W
) (
  input  repl_pol_e                       pol,
  input  logic                            vic_req,
  input  logic [WAYS-1:0]                 valid,
  input  logic [WAYS-1:0][CNT_W-1:0]      cnt,
  input  logic [WAYS-1:0][RANK_W-1:0]     rank,
  output logic [IDX_W-1:0]                vic_way
);

  // Smaller key means a better eviction candidate. Empty ways key to zero,
  // valid ways order by count (policy dependent) and then by age.
  logic [WAYS-1:0][KEY_W-1:0] key;

  for (genvar g = 0; g < WAYS; g++) begin : g_key
    logic [CNT_W-1:0] cnt_term;
    assign cnt_term = (pol == POL_LFRU) ? cnt[g] : '0;
    assign key[g]   = valid[g] ? {1'b1, cnt_term, ~rank[g]} : '0;
  end

  logic [IDX_W-1:0] best_idx;
  logic [KEY_W-1:0] best_key;

  always_comb begin
    best_idx = '0;
    best_key = key[0];
    for (int i = 1; i < WAYS; i++) begin
      if (key[i] < best_key) begin
        best_key = key[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign vic_way = vic_req ? best_idx : '0;

endmodule

// File: rtl/lfru_victim_sel.sv
module lfru_victim_sel
  import lfru_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(WAYS),
  localparam int RANK_W = IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic [IDX_W-1:0] acc_way,
  input  logic             acc_fill,
  input  logic             mode_lfru,
  input  logic             vic_req,
  output logic [IDX_W-1:0] vic_way
);

  logic [WAYS-1:0]             valid_q;
  logic [WAYS-1:0][CNT_W-1:0]  cnt_q;
  logic [WAYS-1:0][RANK_W-1:0] rank_q;
  logic [RANK_W-1:0]           acc_rank;
  repl_pol_e                   pol;

  assign acc_rank = rank_q[acc_way];
  assign pol      = repl_pol_e'(mode_lfru);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    lfru_way_state #(
      .WAYS  (WAYS),
      .CNT_W (CNT_W),
      .ID    (w)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_vld  (acc_vld),
      .acc_way  (acc_way),
      .acc_fill (acc_fill),
      .acc_rank (acc_rank),
      .valid_q  (valid_q[w]),
      .cnt_q    (cnt_q[w]),
      .rank_q   (rank_q[w])
    );
  end

  lfru_victim_pick #(
    .WAYS  (WAYS),
    .CNT_W (CNT_W)
  ) u_pick (
    .pol     (pol),
    .vic_req (vic_req),
    .valid   (valid_q),
    .cnt     (cnt_q),
    .rank    (rank_q),
    .vic_way (vic_way)
  );

  // Ranks must stay a permutation of 0..WAYS-1 (R4)
  logic [WAYS-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < WAYS; i++) begin
      rank_seen[rank_q[i]] = 1'b1;
    end
  end

  p_rank_permutation_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&rank_seen));

  // R5: an empty way is always preferred
  p_empty_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_req && !(&valid_q)) |-> !valid_q[vic_way]);

  // R6: least recently used mode names the oldest way
  p_lru_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_req && (&valid_q) && !mode_lfru) |-> (rank_q[vic_way] == RANK_W'(WAYS-1)));

  // R10: no request, index reads zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_req |-> (vic_way == '0));

endmodule

// File: tb/lfru_victim_sel_tb.sv
`timescale 1ns/100ps
module lfru_victim_sel_tb;

  logic       clk;
  logic       rst_n;
  logic       acc_vld;
  logic [1:0] acc_way;
  logic       acc_fill;
  logic       mode_lfru;
  logic       vic_req;
  logic [1:0] vic_way;

  int  n_run;
  int  n_fail;
  bit  done;

  lfru_victim_sel u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_vld   (acc_vld),
    .acc_way   (acc_way),
    .acc_fill  (acc_fill),
    .mode_lfru (mode_lfru),
    .vic_req   (vic_req),
    .vic_way   (vic_way)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {acc, fill, way[1:0], mode, expected victim[1:0]}
  localparam logic [6:0] VEC [18] = '{
    7'b1_1_10_0_00, 7'b1_1_00_0_01, 7'b1_1_11_0_01, 7'b1_1_01_0_10,
    7'b1_0_10_0_00, 7'b1_0_00_1_11, 7'b1_0_11_1_01, 7'b1_0_01_1_10,
    7'b1_0_10_1_00, 7'b1_0_00_1_11, 7'b1_0_11_1_01, 7'b1_0_10_1_01,
    7'b1_0_01_0_00, 7'b0_0_00_1_00, 7'b1_0_00_0_11, 7'b0_0_00_1_11,
    7'b1_0_11_0_10, 7'b0_0_00_1_01
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: vic_way=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] way, input logic fill, input logic lfru);
    @(negedge clk);
    acc_vld   = 1'b1;
    acc_way   = way;
    acc_fill  = fill;
    mode_lfru = lfru;
    vic_req   = 1'b1;
    @(negedge clk);
    acc_vld = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; acc_vld = 1'b0; acc_way = '0; acc_fill = 1'b0;
    mode_lfru = 1'b0; vic_req = 1'b0;
    do_reset();

    // R1 reset state, R10 idle output
    vic_req = 1'b1; #1;
    check("R1 reset victim", vic_way, 2'd0);
    mode_lfru = 1'b1; #1;
    check("R1 reset victim lfru", vic_way, 2'd0);
    vic_req = 1'b0; #1;
    check("R10 idle after reset", vic_way, 2'd0);

    // Vector walk: R2 R4 R5 R6 R7 R8
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      acc_vld   = VEC[k][6];
      acc_fill  = VEC[k][5];
      acc_way   = VEC[k][4:3];
      mode_lfru = VEC[k][2];
      vic_req   = 1'b1;
      @(negedge clk);
      acc_vld = 1'b0;
      #1;
      check($sformatf("R4 R5 R6 R7 R8 vector %0d", k), vic_way, VEC[k][1:0]);
    end

    // R3 saturation: 13 hits take way1 from 3 to 15, not past it
    for (int k = 0; k < 13; k++) access(2'd1, 1'b0, 1'b1);
    check("R3 counter saturates", vic_way, 2'd2);

    // R9 same-cycle victim reflects old state
    @(negedge clk);
    acc_vld = 1'b1; acc_way = 2'd2; acc_fill = 1'b0; mode_lfru = 1'b1; vic_req = 1'b1;
    #1;
    check("R9 before edge", vic_way, 2'd2);
    @(negedge clk);
    acc_vld = 1'b0;
    #1;
    check("R9 after edge", vic_way, 2'd0);

    // R2 refill of a heavily used way resets count to 1
    access(2'd1, 1'b1, 1'b1);
    check("R2 refill resets count", vic_way, 2'd1);

    // R10 request low
    vic_req = 1'b0; #1;
    check("R10 idle", vic_way, 2'd0);

    // R1 mid-run reset, then R5 fill order
    do_reset();
    vic_req = 1'b1; mode_lfru = 1'b0; #1;
    check("R1 mid-run reset", vic_way, 2'd0);
    access(2'd0, 1'b1, 1'b0);
    check("R5 first empty", vic_way, 2'd1);
    access(2'd3, 1'b1, 1'b1);
    check("R5 empty before valid", vic_way, 2'd1);
    access(2'd1, 1'b1, 1'b0);
    check("R5 last empty", vic_way, 2'd2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule